// File: doc/BRIEF.md
# Interrupt Preemption Decision Unit

This block decides, once per clock, whether the highest-priority pending interrupt presented to a processor interface may interrupt the processor now. It takes several inputs: the pending interrupt's 8-bit priority and group code, three banks of active-priority bits (one per group), a priority mask, a per-group enable, three binary-point values and two common-binary-point controls. From these it forms the current running priority and a preempt flag. Numerically lower priority values are more urgent.

The running priority comes from the lowest-numbered bit that is set anywhere in the OR of the three banks. That bit index is scaled by the minimum binary point. When a running interrupt exists, the pending interrupt wins only on its group-priority bits. The binary point for the pending interrupt's group sets which bits those are, and for either group-1 kind that binary point can be replaced by the group 0 binary point. Selecting the pending interrupt, acknowledge and end-of-interrupt handling, and register decoding all sit outside this block. It has no streaming data path, so every pin is a plain control or status signal with no handshake.

Top module: `preempt_decider`

## Requirements
- R1: A pending priority of 0xFF means nothing is pending, and `preempt` is then 0.
- R2: Group codes are 0 = group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = reserved. `grp_en[g]` enables group code g. If the pending group's enable bit is 0, or the code is 3, `preempt` is 0.
- R3: A pending priority greater than or equal to `pri_mask` never preempts.
- R4: Flattened bank bit i (word i/32, bit i%32) stands for active index i. The running priority is (lowest i set in act_g0|act_g1s|act_g1ns) shifted left by MIN_BP+1, with lower words taking precedence over higher words.
- R5: When no bank bit is set, `run_prio` is 0xFF, and any enabled pending interrupt below the mask preempts.
- R6: With a running interrupt, `preempt` is 1 only if (pend & M) < (run & M) holds strictly, where M = 0xFF << (bp+1). Bits below the group-priority field do not count.
- R7: Group 0 always uses `bp_g0`. Secure group 1 uses `bp_g0` when `cbp_sec` is 1 and `bp_g1s` otherwise. Non-secure group 1 uses `bp_g0` when `cbp_nsec` is 1 and `bp_g1ns` otherwise.
- R8: Both outputs are registered, so they reflect the inputs of the previous clock edge. Reset drives `preempt` to 0 and `run_prio` to 0xFF.
- R9: A binary point of 7 leaves no group-priority bits, so a running interrupt is never preempted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_prio | input | 8 | Priority of highest pending interrupt (0xFF = none) |
| pend_grp | input | 2 | Group code of pending interrupt |
| grp_en | input | 3 | Per-group enable, indexed by group code |
| pri_mask | input | 8 | Priority mask threshold |
| act_g0 | input | WORDS*32 (32 default) | Group 0 active-priority bits |
| act_g1s | input | WORDS*32 (32 default) | Secure group 1 active-priority bits |
| act_g1ns | input | WORDS*32 (32 default) | Non-secure group 1 active-priority bits |
| bp_g0 | input | 3 | Group 0 binary point |
| bp_g1s | input | 3 | Secure group 1 binary point |
| bp_g1ns | input | 3 | Non-secure group 1 binary point |
| cbp_sec | input | 1 | Secure group 1 uses group 0 binary point |
| cbp_nsec | input | 1 | Non-secure group 1 uses group 0 binary point |
| preempt | output | 1 | Registered preempt decision |
| run_prio | output | 8 | Registered running priority |

## Verification
The bench builds two instances side by side. The first uses the default minimum binary point of 2, which gives one 32-bit word per bank and a shift of 3. The second uses a minimum binary point of 0, which gives four words per bank and a shift of 1. The default instance covers masking, enables, binary-point redirection and the full-width masks from binary point 0 to 7. The second instance reaches the scan across several words, where an empty low word must be skipped and a lower word must win over a higher one.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
  typedef enum logic [1:0] {
    GRP_0    = 2'd0,
    GRP_1S   = 2'd1,
    GRP_1NS  = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  localparam logic [7:0] IDLE_PRIO = 8'hFF;
endpackage

// File: rtl/pdu_prio_scan.sv
module pdu_prio_scan #(
  parameter int WORDS    = 1,
  parameter int ACT_BITS = 32,
  parameter int IDX_W    = 5
) (
  input  logic [WORDS*32-1:0] bank_a,
  input  logic [WORDS*32-1:0] bank_b,
  input  logic [WORDS*32-1:0] bank_c,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  logic [31:0] word_or  [WORDS];
  logic        word_any [WORDS];
  logic [4:0]  word_low [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int HI = ACT_BITS - w * 32;
    localparam logic [31:0] VALID = (HI >= 32) ? 32'hFFFF_FFFF
                                               : ((32'h1 << HI) - 32'h1);
    assign word_or[w]  = (bank_a[w*32 +: 32] | bank_b[w*32 +: 32] |
                          bank_c[w*32 +: 32]) & VALID;
    assign word_any[w] = |word_or[w];

    always_comb begin
      word_low[w] = 5'd0;
      for (int b = 31; b >= 0; b--) begin
        if (word_or[w][b]) word_low[w] = 5'(b);
      end
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int w = WORDS - 1; w >= 0; w--) begin
      if (word_any[w]) begin
        found = 1'b1;
        idx   = IDX_W'(w * 32 + int'(word_low[w]));
      end
    end
  end
endmodule

// File: rtl/pdu_gprio_mask.sv
module pdu_gprio_mask
  import pdu_pkg::*;
(
  input  grp_e       grp,
  input  logic [2:0] bp_g0,
  input  logic [2:0] bp_g1s,
  input  logic [2:0] bp_g1ns,
  input  logic       cbp_sec,
  input  logic       cbp_nsec,
  output logic [7:0] mask
);
  logic [2:0] bp_sel;
  logic [8:0] wide;

  always_comb begin
    unique case (grp)
      GRP_1S:  bp_sel = cbp_sec  ? bp_g0 : bp_g1s;
      GRP_1NS: bp_sel = cbp_nsec ? bp_g0 : bp_g1ns;
      default: bp_sel = bp_g0;
    endcase
    wide = 9'h1FF << (4'(bp_sel) + 4'd1);
    mask = wide[7:0];
  end
endmodule

// File: rtl/pdu_pend_gate.sv
module pdu_pend_gate
  import pdu_pkg::*;
(
  input  logic [7:0] pend_prio,
  input  grp_e       grp,
  input  logic [2:0] grp_en,
  input  logic [7:0] pri_mask,
  output logic       eligible
);
  logic grp_on;

  always_comb begin
    unique case (grp)
      GRP_0:   grp_on = grp_en[0];
      GRP_1S:  grp_on = grp_en[1];
      GRP_1NS: grp_on = grp_en[2];
      default: grp_on = 1'b0;
    endcase
    eligible = (pend_prio != IDLE_PRIO) && grp_on && (pend_prio < pri_mask);
  end
endmodule

// File: rtl/preempt_decider.sv
module preempt_decider
  import pdu_pkg::*;
#(
  parameter int  MIN_BP    = 2,
  localparam int PRIO_BITS = 7 - MIN_BP,
  localparam int ACT_BITS  = 1 << PRIO_BITS,
  localparam int WORDS     = (ACT_BITS + 31) / 32,
  localparam int BANK_W    = WORDS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        pend_prio,
  input  logic [1:0]        pend_grp,
  input  logic [2:0]        grp_en,
  input  logic [7:0]        pri_mask,
  input  logic [BANK_W-1:0] act_g0,
  input  logic [BANK_W-1:0] act_g1s,
  input  logic [BANK_W-1:0] act_g1ns,
  input  logic [2:0]        bp_g0,
  input  logic [2:0]        bp_g1s,
  input  logic [2:0]        bp_g1ns,
  input  logic              cbp_sec,
  input  logic              cbp_nsec,
  output logic              preempt,
  output logic [7:0]        run_prio
);
  grp_e                 grp;
  logic                 act_found;
  logic [PRIO_BITS-1:0] act_idx;
  logic [7:0]           run_next;
  logic [7:0]           gmask;
  logic                 eligible;
  logic                 wins;

  assign grp = grp_e'(pend_grp);

  pdu_prio_scan #(
    .WORDS   (WORDS),
    .ACT_BITS(ACT_BITS),
    .IDX_W   (PRIO_BITS)
  ) u_scan (
    .bank_a(act_g0),
    .bank_b(act_g1s),
    .bank_c(act_g1ns),
    .found (act_found),
    .idx   (act_idx)
  );

  pdu_gprio_mask u_mask (
    .grp     (grp),
    .bp_g0   (bp_g0),
    .bp_g1s  (bp_g1s),
    .bp_g1ns (bp_g1ns),
    .cbp_sec (cbp_sec),
    .cbp_nsec(cbp_nsec),
    .mask    (gmask)
  );

  pdu_pend_gate u_gate (
    .pend_prio(pend_prio),
    .grp      (grp),
    .grp_en   (grp_en),
    .pri_mask (pri_mask),
    .eligible (eligible)
  );

  assign run_next = act_found ? {act_idx, {(MIN_BP + 1){1'b0}}} : IDLE_PRIO;
  assign wins     = !act_found || ((pend_prio & gmask) < (run_next & gmask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preempt  <= 1'b0;
      run_prio <= IDLE_PRIO;
    end else begin
      preempt  <= eligible && wins;
      run_prio <= run_next;
    end
  end
endmodule

// File: rtl/pdu_checker.sv
module pdu_checker #(
  parameter int MIN_BP = 2,
  parameter int BANK_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        pend_prio,
  input logic [1:0]        pend_grp,
  input logic [2:0]        grp_en,
  input logic [7:0]        pri_mask,
  input logic [BANK_W-1:0] act_g0,
  input logic [BANK_W-1:0] act_g1s,
  input logic [BANK_W-1:0] act_g1ns,
  input logic              preempt,
  input logic [7:0]        run_prio
);
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || !preempt));

  assert_nopend_R1: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(pend_prio == 8'hFF) |-> !preempt);

  assert_grp_off_R2: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(pend_grp == 2'd3 || !grp_en[pend_grp]) |-> !preempt);

  assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past(pend_prio >= pri_mask) |-> !preempt);

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    $past((act_g0 | act_g1s | act_g1ns) == '0) |-> run_prio == 8'hFF);

  assert_scaled_R4: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    run_prio != 8'hFF |-> run_prio[MIN_BP:0] == '0);

  assert_strict_R6: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (run_prio != 8'hFF && $past(pend_prio) >= run_prio) |-> !preempt);
endmodule

bind preempt_decider pdu_checker #(
  .MIN_BP(MIN_BP),
  .BANK_W(BANK_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pend_prio(pend_prio),
  .pend_grp (pend_grp),
  .grp_en   (grp_en),
  .pri_mask (pri_mask),
  .act_g0   (act_g0),
  .act_g1s  (act_g1s),
  .act_g1ns (act_g1ns),
  .preempt  (preempt),
  .run_prio (run_prio)
);

// File: tb/sim_preempt_decider.sv
`timescale 1ns/1ps
module sim_preempt_decider;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   pend_prio = 8'hFF;
  logic [1:0]   pend_grp = 2'd0;
  logic [2:0]   grp_en = 3'b111;
  logic [7:0]   pri_mask = 8'hFF;
  logic [31:0]  act_g0 = '0, act_g1s = '0, act_g1ns = '0;
  logic [127:0] w_g0 = '0, w_g1s = '0, w_g1ns = '0;
  logic [2:0]   bp_g0 = 3'd2, bp_g1s = 3'd2, bp_g1ns = 3'd2;
  logic         cbp_sec = 1'b0, cbp_nsec = 1'b0;
  logic         preempt, preempt_w;
  logic [7:0]   run_prio, run_prio_w;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  preempt_decider u0 (
    .clk(clk), .rst_n(rst_n), .pend_prio(pend_prio), .pend_grp(pend_grp),
    .grp_en(grp_en), .pri_mask(pri_mask), .act_g0(act_g0), .act_g1s(act_g1s),
    .act_g1ns(act_g1ns), .bp_g0(bp_g0), .bp_g1s(bp_g1s), .bp_g1ns(bp_g1ns),
    .cbp_sec(cbp_sec), .cbp_nsec(cbp_nsec), .preempt(preempt), .run_prio(run_prio)
  );

  preempt_decider #(.MIN_BP(0)) u1 (
    .clk(clk), .rst_n(rst_n), .pend_prio(pend_prio), .pend_grp(pend_grp),
    .grp_en(grp_en), .pri_mask(pri_mask), .act_g0(w_g0), .act_g1s(w_g1s),
    .act_g1ns(w_g1ns), .bp_g0(bp_g0), .bp_g1s(bp_g1s), .bp_g1ns(bp_g1ns),
    .cbp_sec(cbp_sec), .cbp_nsec(cbp_nsec), .preempt(preempt_w), .run_prio(run_prio_w)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // apply stimulus at a falling edge, let one rising edge register it
  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    pend_prio = 8'hFF; pend_grp = 2'd0; grp_en = 3'b111; pri_mask = 8'hFF;
    act_g0 = '0; act_g1s = '0; act_g1ns = '0;
    w_g0 = '0; w_g1s = '0; w_g1ns = '0;
    bp_g0 = 3'd2; bp_g1s = 3'd2; bp_g1ns = 3'd2;
    cbp_sec = 1'b0; cbp_nsec = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reset preempt", preempt, 0);
    check("R8 reset run_prio", run_prio, 8'hFF);
  endtask

  task automatic t_idle();
    clear_all(); pend_prio = 8'h40; step();
    check("R5 idle run_prio", run_prio, 8'hFF);
    check("R5 idle preempt", preempt, 1);
    pend_prio = 8'h00; step();
    check("R5 idle prio 0", preempt, 1);
  endtask

  task automatic t_nopend();
    clear_all(); pend_prio = 8'hFF; step();
    check("R1 nothing pending", preempt, 0);
  endtask

  task automatic t_mask();
    clear_all(); pend_prio = 8'h40; pri_mask = 8'h40; step();
    check("R3 equal to mask", preempt, 0);
    pri_mask = 8'h30; step();
    check("R3 above mask", preempt, 0);
    pri_mask = 8'h41; step();
    check("R3 just below mask", preempt, 1);
  endtask

  task automatic t_enable();
    clear_all(); pend_prio = 8'h10; pend_grp = 2'd2; grp_en = 3'b011; step();
    check("R2 group 1ns disabled", preempt, 0);
    grp_en = 3'b100; step();
    check("R2 group 1ns enabled", preempt, 1);
    pend_grp = 2'd0; step();
    check("R2 group 0 disabled", preempt, 0);
    pend_grp = 2'd3; grp_en = 3'b111; step();
    check("R2 reserved group", preempt, 0);
  endtask

  task automatic t_scan();
    clear_all(); act_g1s[5] = 1'b1; act_g1ns[9] = 1'b1; step();
    check("R4 lowest of two banks", run_prio, 8'h28);
    act_g0[0] = 1'b1; step();
    check("R4 bit zero", run_prio, 8'h00);
    act_g0 = '0; act_g1s = '0; act_g1ns = '0; act_g1ns[31] = 1'b1; step();
    check("R4 top bit", run_prio, 8'hF8);
  endtask

  task automatic t_compare();
    clear_all(); act_g0[8] = 1'b1; pend_grp = 2'd0;
    pend_prio = 8'h38; bp_g0 = 3'd2; step();
    check("R6 run_prio", run_prio, 8'h40);
    check("R6 more urgent group", preempt, 1);
    pend_prio = 8'h40; step();
    check("R6 equal not preempt", preempt, 0);
    pend_prio = 8'h38; bp_g0 = 3'd3; step();
    check("R6 bp3 0x30<0x40", preempt, 1);
    pend_prio = 8'h4F; step();
    check("R6 subpriority ignored", preempt, 0);
    pend_prio = 8'h10; bp_g0 = 3'd6; step();
    check("R6 bp6 same group", preempt, 0);
    act_g0 = '0; act_g0[16] = 1'b1; step();
    check("R6 bp6 running 0x80", preempt, 1);
  endtask

  task automatic t_bp7();
    clear_all(); act_g0[16] = 1'b1; pend_prio = 8'h00; bp_g0 = 3'd7; step();
    check("R9 bp7 never preempts", preempt, 0);
  endtask

  task automatic t_cbpr();
    clear_all(); act_g0[8] = 1'b1; pend_prio = 8'h38; bp_g0 = 3'd0;
    pend_grp = 2'd1; bp_g1s = 3'd6; cbp_sec = 1'b0; step();
    check("R7 g1s own bp", preempt, 0);
    cbp_sec = 1'b1; step();
    check("R7 g1s common bp", preempt, 1);
    pend_grp = 2'd2; bp_g1ns = 3'd6; cbp_nsec = 1'b0; step();
    check("R7 g1ns ignores secure common bit", preempt, 0);
    cbp_nsec = 1'b1; step();
    check("R7 g1ns common bp", preempt, 1);
    pend_grp = 2'd0; bp_g1s = 3'd0; bp_g0 = 3'd6; cbp_sec = 1'b0; step();
    check("R7 g0 uses own bp", preempt, 0);
  endtask

  task automatic t_latency();
    clear_all(); step();
    check("R8 idle before", preempt, 0);
    pend_prio = 8'h20; #1;
    check("R8 not before edge", preempt, 0);
    step();
    check("R8 after one edge", preempt, 1);
  endtask

  task automatic t_wide();
    clear_all(); w_g1ns[67] = 1'b1; w_g0[100] = 1'b1; step();
    check("R4 multi-word skip empty", run_prio_w, 8'h86);
    w_g1s[40] = 1'b1; step();
    check("R4 lower word wins", run_prio_w, 8'h50);
    w_g1s = '0; pend_prio = 8'h84; pend_grp = 2'd0; bp_g0 = 3'd0; step();
    check("R6 wide instance preempts", preempt_w, 1);
    pend_prio = 8'h87; step();
    check("R6 wide subpriority", preempt_w, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_nopend();
    t_mask();
    t_enable();
    t_scan();
    t_compare();
    t_bp7();
    t_cbpr();
    t_latency();
    t_wide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule